// File: doc/BRIEF.md
# MII management register bridge

This block lets a host reach the registers of an Ethernet PHY through a small byte-wide register bank. The host picks a PHY register by number and then either starts a read by setting a command bit, or starts a write by loading two data bytes. The block serialises a management frame on MDC/MDIO, collects the reply on reads, and shows a busy flag for as long as the frame is on the wire.

A frame is 64 MDC periods: 32 preamble ones, start `01`, opcode, PHY address (a parameter), register address, turnaround and 16 data bits, most significant first. MDC is made from the system clock by a divider of `2*MDC_HALF` clocks per period. With the default `MDC_HALF = 4` at 50 MHz, one operation lasts 512 clocks, which is 10.24 µs. The read command bit stays set until the host clears it, and a write is launched by the write to the high data byte.

Top module: `mgmt_bridge`

## Requirements
- R1: After reset every bank register reads 0x00, MDC is low and MDIO is released (`mdio_oe` = 0). Whenever the block is idle, MDC stays low and MDIO stays released.
- R2: A write to address 1 (command, bit 0 = read start) with bit 0 = 1, while that bit is 0 and the block is idle, starts a read frame and sets busy from the next clock.
- R3: A write to address 3 (high write byte) while idle launches a write frame carrying {that byte, address 2 low write byte} and sets busy from the next clock.
- R4: The frame sent is 32 ones, `01`, opcode `10` for read or `01` for write, PHY_ADDR, the 5-bit register number held at address 0 (bits 4:0), then for writes turnaround `10` and the 16 data bits MSB first. Each bit changes only on the falling MDC transition and holds while MDC is high.
- R5: MDC has a period of 2*MDC_HALF clocks, low for the first half and high for the second, and each operation is exactly 64 MDC periods. Busy is therefore high for 128*MDC_HALF clocks (512 by default).
- R6: During a read, `mdio_oe` drops from frame bit 46 (turnaround) to the end. `mdio_i` is sampled as MDC rises in bits 48 to 63, and when busy clears the result reads back from address 4 (low byte) and address 5 (high byte).
- R7: Reading any register has no side effect: the two read bytes give the same values in either order and on repeated reads.
- R8: The read command bit is not cleared by the block. It reads back 1 after the read completes, and writing 1 again while it is 1 starts nothing. A new read needs a write of 0 and then a write of 1.
- R9: While busy, writes to address 1 and address 3 are ignored. Their read-back values stay the same, and no frame is started or restarted.
- R10: Address 6 bit 0 shows busy, address 7 reads 0, and addresses 0 to 3 read back the values the host has written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (0 = released) |
| mdio_i | input | 1 | MDIO input value |

## Verification
The assertions check the following on every cycle:
- MDIO holds steady while MDC is high.
- MDC is low and MDIO is released whenever the block is idle.
- Every busy period is exactly one frame long.
- Busy only rises right after a host write to the command or high write-data register.
- The status register mirrors busy.
- The read data stays frozen during an operation.

Some behaviours only the bench scenarios can show:
- The bit-exact frame content for chosen register numbers and data, checked against a cycle-by-cycle model.
- The captured read value returned by a responding PHY.
- The read command bit surviving completion and needing a clear before a new start.
- Writes made during busy leaving the read-back values unchanged.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

  localparam int FRAME_BITS = 64;
  localparam int TA_BIT     = 46;
  localparam int DATA_BIT   = 48;

  localparam logic [2:0] A_REGADDR = 3'd0;
  localparam logic [2:0] A_CMD     = 3'd1;
  localparam logic [2:0] A_WLO     = 3'd2;
  localparam logic [2:0] A_WHI     = 3'd3;
  localparam logic [2:0] A_RLO     = 3'd4;
  localparam logic [2:0] A_RHI     = 3'd5;
  localparam logic [2:0] A_STATUS  = 3'd6;

  typedef enum logic {OP_WRITE = 1'b0, OP_READ = 1'b1} mgmt_op_e;

  // Whole frame, bit 63 leaves first. Read frames carry ones where the line is released.
  function automatic logic [FRAME_BITS-1:0] build_frame(
    input mgmt_op_e    op,
    input logic [4:0]  phy,
    input logic [4:0]  regn,
    input logic [15:0] data
  );
    logic [1:0]  opc;
    logic [1:0]  ta;
    logic [15:0] pay;
    opc = (op == OP_READ) ? 2'b10 : 2'b01;
    ta  = (op == OP_READ) ? 2'b11 : 2'b10;
    pay = (op == OP_READ) ? 16'hFFFF : data;
    return {32'hFFFF_FFFF, 2'b01, opc, phy, regn, ta, pay};
  endfunction

endpackage

// File: rtl/mgmt_mdc_gen.sv
module mgmt_mdc_gen #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic wrap_o
);

  localparam int PERIOD = 2 * HALF;
  localparam int CW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] CNT_HALF = CW'(HALF - 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (start_i || !run_i) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_HALF) mdc_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = run_i && !start_i && (cnt_q == CNT_HALF);
  assign wrap_o = run_i && !start_i && (cnt_q == CNT_LAST);

endmodule

// File: rtl/mgmt_frame_engine.sv
module mgmt_frame_engine
  import mgmt_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR = 5'h01,
  parameter int         HALF     = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  mgmt_op_e    op_i,
  input  logic [4:0]  reg_i,
  input  logic [15:0] wdata_i,
  input  logic        mdio_i,
  output logic        busy_o,
  output logic        done_o,
  output mgmt_op_e    op_o,
  output logic [15:0] cap_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o
);

  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);
  localparam logic [BW-1:0] TA_IDX   = BW'(TA_BIT);
  localparam logic [BW-1:0] DAT_IDX  = BW'(DATA_BIT);

  logic                  active_q, active_d;
  mgmt_op_e              op_q, op_d;
  logic [BW-1:0]         bit_q, bit_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [15:0]           cap_q, cap_d;
  logic                  rise, wrap, last;

  mgmt_mdc_gen #(.HALF(HALF)) u_mdc (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .run_i  (active_q),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .wrap_o (wrap)
  );

  assign last = wrap && (bit_q == LAST_BIT);

  always_comb begin
    active_d = active_q;
    op_d     = op_q;
    bit_d    = bit_q;
    sh_d     = sh_q;
    cap_d    = cap_q;
    if (start_i) begin
      active_d = 1'b1;
      op_d     = op_i;
      bit_d    = '0;
      sh_d     = build_frame(op_i, PHY_ADDR, reg_i, wdata_i);
    end else if (wrap) begin
      sh_d = {sh_q[FRAME_BITS-2:0], 1'b1};
      if (last) active_d = 1'b0;
      else      bit_d    = bit_q + 1'b1;
    end
    if (rise && (op_q == OP_READ) && (bit_q >= DAT_IDX)) begin
      cap_d = {cap_q[14:0], mdio_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      op_q     <= OP_WRITE;
      bit_q    <= '0;
      sh_q     <= '0;
      cap_q    <= '0;
    end else begin
      active_q <= active_d;
      op_q     <= op_d;
      bit_q    <= bit_d;
      sh_q     <= sh_d;
      cap_q    <= cap_d;
    end
  end

  assign busy_o    = active_q;
  assign done_o    = last;
  assign op_o      = op_q;
  assign cap_o     = cap_q;
  assign mdio_o    = active_q & sh_q[FRAME_BITS-1];
  assign mdio_oe_o = active_q && !((op_q == OP_READ) && (bit_q >= TA_IDX));

endmodule

// File: rtl/mgmt_regbank.sv
module mgmt_regbank
  import mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        busy_i,
  input  logic        done_i,
  input  mgmt_op_e    done_op_i,
  input  logic [15:0] cap_i,
  output logic        start_o,
  output mgmt_op_e    op_o,
  output logic [4:0]  reg_o,
  output logic [15:0] wdata_o
);

  logic [4:0] regaddr_q, regaddr_d;
  logic       cmd_q, cmd_d;
  logic [7:0] wlo_q, wlo_d;
  logic [7:0] whi_q, whi_d;
  logic [7:0] rlo_q, rlo_d;
  logic [7:0] rhi_q, rhi_d;
  logic       wr_cmd, wr_whi, start_rd, start_wr;

  assign wr_cmd   = bus_wr && (bus_addr == A_CMD) && !busy_i;
  assign wr_whi   = bus_wr && (bus_addr == A_WHI) && !busy_i;
  assign start_rd = wr_cmd && bus_wdata[0] && !cmd_q;
  assign start_wr = wr_whi;

  always_comb begin
    regaddr_d = regaddr_q;
    cmd_d     = cmd_q;
    wlo_d     = wlo_q;
    whi_d     = whi_q;
    rlo_d     = rlo_q;
    rhi_d     = rhi_q;
    if (bus_wr && (bus_addr == A_REGADDR)) regaddr_d = bus_wdata[4:0];
    if (bus_wr && (bus_addr == A_WLO))     wlo_d     = bus_wdata;
    if (wr_cmd)                            cmd_d     = bus_wdata[0];
    if (wr_whi)                            whi_d     = bus_wdata;
    if (done_i && (done_op_i == OP_READ)) begin
      rlo_d = cap_i[7:0];
      rhi_d = cap_i[15:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regaddr_q <= '0;
      cmd_q     <= 1'b0;
      wlo_q     <= '0;
      whi_q     <= '0;
      rlo_q     <= '0;
      rhi_q     <= '0;
    end else begin
      regaddr_q <= regaddr_d;
      cmd_q     <= cmd_d;
      wlo_q     <= wlo_d;
      whi_q     <= whi_d;
      rlo_q     <= rlo_d;
      rhi_q     <= rhi_d;
    end
  end

  always_comb begin
    case (bus_addr)
      A_REGADDR: bus_rdata = {3'b000, regaddr_q};
      A_CMD:     bus_rdata = {7'b0, cmd_q};
      A_WLO:     bus_rdata = wlo_q;
      A_WHI:     bus_rdata = whi_q;
      A_RLO:     bus_rdata = rlo_q;
      A_RHI:     bus_rdata = rhi_q;
      A_STATUS:  bus_rdata = {7'b0, busy_i};
      default:   bus_rdata = 8'h00;
    endcase
  end

  assign start_o = start_rd || start_wr;
  assign op_o    = start_rd ? OP_READ : OP_WRITE;
  assign reg_o   = regaddr_q;
  assign wdata_o = {bus_wdata, wlo_q};

endmodule

// File: rtl/mgmt_bridge.sv
module mgmt_bridge
  import mgmt_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR = 5'h01,
  parameter int         MDC_HALF = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       mdc,
  output logic       mdio_o,
  output logic       mdio_oe,
  input  logic       mdio_i
);

  logic        rst_s1_q, rst_s2_q, rst_int_n;
  logic        eng_busy, eng_done, start;
  mgmt_op_e    eng_op, start_op;
  logic [4:0]  start_reg;
  logic [15:0] start_data, cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  mgmt_regbank u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .busy_i   (eng_busy),
    .done_i   (eng_done),
    .done_op_i(eng_op),
    .cap_i    (cap),
    .start_o  (start),
    .op_o     (start_op),
    .reg_o    (start_reg),
    .wdata_o  (start_data)
  );

  mgmt_frame_engine #(.PHY_ADDR(PHY_ADDR), .HALF(MDC_HALF)) u_eng (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start_i  (start),
    .op_i     (start_op),
    .reg_i    (start_reg),
    .wdata_i  (start_data),
    .mdio_i   (mdio_i),
    .busy_o   (eng_busy),
    .done_o   (eng_done),
    .op_o     (eng_op),
    .cap_o    (cap),
    .mdc_o    (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe_o(mdio_oe)
  );

endmodule

// File: rtl/mgmt_bridge_chk.sv
module mgmt_bridge_chk
  import mgmt_pkg::*;
#(
  parameter int MDC_HALF = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] bus_addr,
  input logic       bus_wr,
  input logic [7:0] bus_rdata,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic       busy
);

  localparam int FRAME_CYCLES = FRAME_BITS * 2 * MDC_HALF;

  int unsigned span_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    span_q <= 0;
    else if (busy) span_q <= span_q + 1;
    else           span_q <= 0;
  end

  AST_MDIO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe)); // R1

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (span_q == FRAME_CYCLES)); // R5

  AST_LAUNCH_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(bus_wr) && (($past(bus_addr) == A_CMD) || ($past(bus_addr) == A_WHI)))); // R2

  AST_STATUS_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_STATUS) |-> (bus_rdata == {7'b0, busy})); // R10

  AST_RDATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (bus_addr == A_RLO) && ($past(bus_addr) == A_RLO)) |-> $stable(bus_rdata)); // R7

endmodule

bind mgmt_bridge mgmt_bridge_chk #(.MDC_HALF(MDC_HALF)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_rdata(bus_rdata),
  .mdc      (mdc),
  .mdio_o   (mdio_o),
  .mdio_oe  (mdio_oe),
  .busy     (eng_busy)
);

// File: tb/test_mgmt_bridge.sv
`timescale 1ns/1ps
module test_mgmt_bridge;
  import mgmt_pkg::*;

  localparam logic [4:0] PHY    = 5'h0B;
  localparam int         HALF   = 4;
  localparam int         PERIOD = 2 * HALF;
  localparam int         FCYC   = 64 * PERIOD;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       mdc, mdio_o, mdio_oe, mdio_i;

  int n_chk  = 0;
  int n_fail = 0;
  int n_rise = 0;
  bit finished = 1'b0;

  // behavioural reference state
  bit          m_busy;
  int          m_e;
  mgmt_op_e    m_op;
  logic [63:0] m_frame;
  logic [4:0]  m_reg;
  logic        m_cmd;
  logic [7:0]  m_wlo, m_whi, m_rlo, m_rhi;
  logic [15:0] m_rdv;
  logic [15:0] phy_val;
  logic        phy_on, phy_bit;

  always #10 clk = ~clk;

  mgmt_bridge #(.PHY_ADDR(PHY), .MDC_HALF(HALF)) i_mgmt_bridge (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY responder: drives turnaround low then data MSB first during read frames
  always @* begin
    int b;
    b = m_e / PERIOD;
    phy_on  = m_busy && (m_op == OP_READ) && (b >= 46);
    phy_bit = (b >= 48 && b < 64) ? m_rdv[63 - b] : 1'b0;
  end
  assign mdio_i = mdio_oe ? mdio_o : (phy_on ? phy_bit : 1'b1);

  always @(posedge mdc) n_rise++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_rd(input logic [2:0] a);
    case (a)
      3'd0: return {3'b000, m_reg};
      3'd1: return {7'b0, m_cmd};
      3'd2: return m_wlo;
      3'd3: return m_whi;
      3'd4: return m_rlo;
      3'd5: return m_rhi;
      3'd6: return {7'b0, m_busy};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    bit old_busy;
    if (!rst_n) begin
      m_busy = 0; m_e = 0; m_op = OP_WRITE; m_frame = '0; m_reg = '0; m_cmd = 0;
      m_wlo = 0; m_whi = 0; m_rlo = 0; m_rhi = 0; m_rdv = 0;
    end else begin
      old_busy = m_busy;
      if (m_busy) begin
        m_e++;
        if (m_e == FCYC) begin
          m_busy = 0;
          if (m_op == OP_READ) {m_rhi, m_rlo} = m_rdv;
        end
      end
      if (bus_wr) begin
        case (bus_addr)
          3'd0: m_reg = bus_wdata[4:0];
          3'd2: m_wlo = bus_wdata;
          3'd1: if (!old_busy) begin
            if (bus_wdata[0] && !m_cmd) begin
              m_busy = 1; m_e = 0; m_op = OP_READ; m_rdv = phy_val;
              m_frame = {32'hFFFF_FFFF, 2'b01, 2'b10, PHY, m_reg, 18'h3FFFF};
            end
            m_cmd = bus_wdata[0];
          end
          3'd3: if (!old_busy) begin
            m_whi = bus_wdata;
            m_busy = 1; m_e = 0; m_op = OP_WRITE;
            m_frame = {32'hFFFF_FFFF, 2'b01, 2'b01, PHY, m_reg, 2'b10, bus_wdata, m_wlo};
          end
          default: ;
        endcase
      end
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    int  b;
    bit  e_mdc, e_oe;
    if (rst_n && !finished) begin
      b     = m_e / PERIOD;
      e_mdc = m_busy && ((m_e % PERIOD) >= HALF);
      e_oe  = m_busy && !((m_op == OP_READ) && (b >= 46));
      chk(mdc == e_mdc, "R5 mdc", int'(mdc), int'(e_mdc));
      chk(mdio_oe == e_oe, "R6 mdio_oe", int'(mdio_oe), int'(e_oe));
      if (e_oe) chk(mdio_o == m_frame[63 - b], "R4 mdio_o", int'(mdio_o), int'(m_frame[63 - b]));
      chk(bus_rdata == model_rd(bus_addr), "R10 bus_rdata", int'(bus_rdata), int'(model_rd(bus_addr)));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #2;
    bus_wr = 1'b0; bus_addr = A_STATUS;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(posedge clk); #2;
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic wait_idle();
    bit idle = 0;
    for (int i = 0; i < 2000 && !idle; i++) begin
      @(posedge clk); #2;
      bus_addr = A_STATUS;
      @(negedge clk);
      if (bus_rdata[0] == 1'b0) idle = 1;
    end
    if (!idle) chk(0, "R5 busy never cleared", 1, 0);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 1, 0);
    summary();
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = A_STATUS; bus_wdata = 8'h00; phy_val = 16'h0000;
    repeat (4) @(posedge clk); #2;
    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      bus_addr = 3'(a); #1;
      chk(bus_rdata == 8'h00, "R1 reset register", int'(bus_rdata), 0);
    end
    chk(mdc == 1'b0, "R1 mdc low", int'(mdc), 0);
    chk(mdio_oe == 1'b0, "R1 mdio released", int'(mdio_oe), 0);
    bus_addr = A_STATUS;
    @(posedge clk); #2; rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R3: write frame
    wr(A_REGADDR, 8'h05);
    wr(A_WLO, 8'h34);
    n_rise = 0;
    wr(A_WHI, 8'h12);
    rd(A_STATUS, v); chk(v == 8'h01, "R3 busy after write launch", int'(v), 1);
    repeat (100) @(posedge clk);
    wr(A_WHI, 8'hEE);   // R9: ignored
    wr(A_CMD, 8'h01);   // R9: ignored
    wait_idle();
    chk(n_rise == 64, "R5 MDC periods per frame", n_rise, 64);
    rd(A_WHI, v); chk(v == 8'h12, "R9 high byte kept while busy", int'(v), 8'h12);
    rd(A_CMD, v); chk(v == 8'h00, "R9 command ignored while busy", int'(v), 0);

    // R2 / R6: read frame
    wr(A_REGADDR, 8'h11);
    phy_val = 16'hA5C3;
    n_rise = 0;
    wr(A_CMD, 8'h01);
    rd(A_STATUS, v); chk(v == 8'h01, "R2 busy after read start", int'(v), 1);
    wait_idle();
    chk(n_rise == 64, "R5 MDC periods per read", n_rise, 64);
    rd(A_RHI, v); chk(v == 8'hA5, "R6 read high byte", int'(v), 8'hA5);
    rd(A_RLO, v); chk(v == 8'hC3, "R6 read low byte", int'(v), 8'hC3);
    rd(A_RHI, v); chk(v == 8'hA5, "R7 high byte after low read", int'(v), 8'hA5);
    rd(A_CMD, v); chk(v == 8'h01, "R8 command bit kept", int'(v), 1);

    // R8: rewriting 1 starts nothing
    wr(A_CMD, 8'h01);
    rd(A_STATUS, v); chk(v == 8'h00, "R8 no restart while bit set", int'(v), 0);
    wr(A_CMD, 8'h00);
    rd(A_CMD, v); chk(v == 8'h00, "R8 host clears command bit", int'(v), 0);

    // second read, with gated writes during busy
    phy_val = 16'h0001;
    wr(A_REGADDR, 8'h1F);
    wr(A_CMD, 8'h01);
    repeat (50) @(posedge clk);
    wr(A_CMD, 8'h00);
    wr(A_WHI, 8'h77);
    wait_idle();
    rd(A_CMD, v); chk(v == 8'h01, "R9 clear ignored while busy", int'(v), 1);
    rd(A_WHI, v); chk(v == 8'h12, "R9 high byte write ignored", int'(v), 8'h12);
    rd(A_RLO, v); chk(v == 8'h01, "R6 read low byte 0001", int'(v), 8'h01);
    rd(A_RHI, v); chk(v == 8'h00, "R6 read high byte 0001", int'(v), 8'h00);

    // all-ones read
    wr(A_CMD, 8'h00);
    phy_val = 16'hFFFF;
    wr(A_REGADDR, 8'h00);
    wr(A_CMD, 8'h01);
    wait_idle();
    rd(A_RLO, v); chk(v == 8'hFF, "R6 read low byte FFFF", int'(v), 8'hFF);
    rd(A_RHI, v); chk(v == 8'hFF, "R6 read high byte FFFF", int'(v), 8'hFF);
    wr(A_CMD, 8'h00);

    // boundary write data, frame checked by the model (R4)
    wr(A_REGADDR, 8'h1F);
    wr(A_WLO, 8'hFF);
    wr(A_WHI, 8'hFF);
    wait_idle();
    wr(A_REGADDR, 8'h00);
    wr(A_WLO, 8'h00);
    wr(A_WHI, 8'h00);
    wait_idle();
    rd(3'd7, v); chk(v == 8'h00, "R10 unused address", int'(v), 0);
    rd(A_REGADDR, v); chk(v == 8'h00, "R10 register number readback", int'(v), 0);
    repeat (5) @(posedge clk);
    summary();
  end

endmodule